// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the control sequencer a 16-bit processor core runs when it takes an interrupt. At each instruction boundary it looks at the interrupt sources and picks the winner. The sources are internal exceptions, the overflow trap, software interrupts, an edge-triggered non-maskable pin, a level-sensitive maskable request pin and the single-step trap. It then saves the machine context and loads the entry point of the service routine. The block owns the flag word. The execute stage can reload the flag word only while no entry sequence is running.

An entry starts with an acknowledge cycle, but only when the maskable pin won. The acknowledge returns the type byte on the low data lines. Next come three word writes to the stack, each one preceded by a two-byte stack pointer decrement. After the writes come two word reads from the vector table, and then a one-cycle completion pulse. The completion pulse carries the new code segment, instruction pointer and stack pointer. The execute stage samples them and resumes fetching. A separate stall output holds a wait operation while the test pin stays high.

Top module: `irq_entry_seq`

## Requirements
- R1: After synchronous reset the flag word is zero, no bus or acknowledge cycle is active, busy is low, and no source is pending. A boundary pulse with no request starts no sequence.
- R2: Each entry writes three 16-bit words, in this order, to physical address ss_cur*16 + offset: flags at offset sp_cur-2, then cs_cur at sp_cur-4, then ip_cur at sp_cur-6. The offsets wrap at 16 bits. sp_new equals sp_cur-6.
- R3: The pushed flag word is the value held before entry. The trap flag (bit 8) and the interrupt-enable flag (bit 9) are both zero once the flag write completes, and they stay zero at completion.
- R4: For type n the block reads the new instruction pointer at byte address 4n and the new code segment at 4n+2. It then raises entry_done for exactly one cycle, with ip_new, cs_new and vec_type valid.
- R5: The non-maskable pin is taken only on a 0-to-1 transition, as type 2. A level held high does not request again. A rising edge that arrives during a sequence is kept and taken at a later boundary.
- R6: The maskable request pin is ignored while bit 9 is 0. When taken, inta_n goes low for a handshake with no memory request, and the type is mem_rdata[7:0] at the cycle mem_ready is high.
- R7: When several sources are active at one boundary, the winner is chosen in this order: internal request first, then the non-maskable edge, then the maskable pin, then single-step.
- R8: Fixed type numbers are as follows. exc_sel 0, 1, 2 and 3 give types 0, 3, 6 and 7. The overflow trap gives type 4 and single-step (bit 8 set) gives type 1. A software interrupt uses swi_type.
- R9: An overflow-trap request has no effect while bit 11 of the flag word is 0.
- R10: wait_stall is high while wait_req and test_pin are both high, and low as soon as test_pin is low.
- R11: A bus cycle lasts until mem_ready is high. While it waits, mem_req, mem_we and mem_addr hold their values.
- R12: A flag load requested while busy is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inst_end | input | 1 | Instruction boundary; sources are arbitrated here |
| nmi_pin | input | 1 | Non-maskable request, rising-edge sensitive |
| intr_pin | input | 1 | Maskable request, active high |
| exc_req | input | 1 | Internal exception request |
| exc_sel | input | 2 | Exception kind: divide, breakpoint, bad opcode, escape |
| into_req | input | 1 | Overflow-trap request |
| swi_req | input | 1 | Software interrupt request |
| swi_type | input | 8 | Type of the software interrupt |
| flags_ld | input | 1 | Load flag word from execute stage |
| flags_d | input | 16 | Flag word to load |
| cs_cur | input | 16 | Code segment to save |
| ip_cur | input | 16 | Instruction pointer to save |
| ss_cur | input | 16 | Stack segment |
| sp_cur | input | 16 | Stack pointer before entry |
| wait_req | input | 1 | A wait operation is executing |
| test_pin | input | 1 | External test input |
| mem_rdata | input | 16 | Read data / acknowledge type byte |
| mem_ready | input | 1 | Bus cycle completes this clock |
| mem_req | output | 1 | Memory cycle active |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 16 | Write data |
| inta_n | output | 1 | Acknowledge strobe, active low |
| busy | output | 1 | Sequence in progress |
| entry_done | output | 1 | One-cycle completion pulse |
| vec_type | output | 8 | Type that was serviced |
| cs_new | output | 16 | Code segment of the service routine |
| ip_new | output | 16 | Instruction pointer of the service routine |
| sp_new | output | 16 | Stack pointer after the pushes |
| flags_q | output | 16 | Current flag word |
| wait_stall | output | 1 | Hold the pipeline for a wait |

## Verification
The hardest case to reach from the ports is a non-maskable edge that arrives while an entry is already running. The pending latch is then the only trace of it. The bench starts a software-interrupt entry and raises the pin in the middle of that entry. After the first entry completes, the bench drops the pin and pulses a bare boundary, so the second entry can come only from the stored edge. The priority chain is reached by raising four sources at once and then draining them one boundary at a time, reloading flags between entries. Wait states come from a memory model that withholds ready, and a flag load is issued inside a stretched sequence.

// File: rtl/irq_pkg.sv
// Shared constants and types of the interrupt entry sequencer.
package irq_pkg;
    // Bit positions inside the flag word that the sequencer reads or clears.
    localparam int FLAG_TF = 8;
    localparam int FLAG_IF = 9;
    localparam int FLAG_OF = 11;

    // Fixed type numbers of the internal sources.
    localparam logic [7:0] TYPE_DIVIDE = 8'd0;
    localparam logic [7:0] TYPE_STEP   = 8'd1;
    localparam logic [7:0] TYPE_NMI    = 8'd2;
    localparam logic [7:0] TYPE_BRKPT  = 8'd3;
    localparam logic [7:0] TYPE_OVF    = 8'd4;
    localparam logic [7:0] TYPE_BADOP  = 8'd6;
    localparam logic [7:0] TYPE_ESCAPE = 8'd7;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_INTERNAL, SRC_NMI, SRC_INTR, SRC_STEP
    } irq_src_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ACK, ST_PSH_FL, ST_PSH_CS, ST_PSH_IP,
        ST_VEC_LO, ST_VEC_HI, ST_DONE
    } seq_state_t;
endpackage

// File: rtl/irq_arbiter.sv
// Source arbiter: keeps the non-maskable edge latch and, at an idle
// instruction boundary, picks one winning source and its type number.
// Assumes: take is acted on in the same cycle by the sequencer.
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int TYPE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              inst_end,
    input  logic              nmi_pin,
    input  logic              intr_pin,
    input  logic              flag_if,
    input  logic              flag_tf,
    input  logic              flag_of,
    input  logic              exc_req,
    input  logic [1:0]        exc_sel,
    input  logic              into_req,
    input  logic              swi_req,
    input  logic [TYPE_W-1:0] swi_type,
    output logic              take,
    output logic              take_ack,
    output logic [TYPE_W-1:0] take_type
);
    logic     nmi_prev;
    logic     nmi_pend;
    logic     nmi_rise;
    irq_src_t winner;
    logic [TYPE_W-1:0] int_type;

    assign nmi_rise = nmi_pin && !nmi_prev;

    // Type of the internal source; exceptions outrank overflow, overflow outranks INT n.
    always_comb begin
        if (exc_req) begin
            unique case (exc_sel)
                2'd0:    int_type = TYPE_W'(TYPE_DIVIDE);
                2'd1:    int_type = TYPE_W'(TYPE_BRKPT);
                2'd2:    int_type = TYPE_W'(TYPE_BADOP);
                default: int_type = TYPE_W'(TYPE_ESCAPE);
            endcase
        end else if (into_req && flag_of) begin
            int_type = TYPE_W'(TYPE_OVF);
        end else begin
            int_type = swi_type;
        end
    end

    // Fixed-priority choice among the active sources.
    always_comb begin
        if (exc_req || (into_req && flag_of) || swi_req) winner = SRC_INTERNAL;
        else if (nmi_pend)                                winner = SRC_NMI;
        else if (intr_pin && flag_if)                     winner = SRC_INTR;
        else if (flag_tf)                                 winner = SRC_STEP;
        else                                              winner = SRC_NONE;
    end

    // Grant outputs toward the sequencer.
    always_comb begin
        take     = idle && inst_end && (winner != SRC_NONE);
        take_ack = (winner == SRC_INTR);
        unique case (winner)
            SRC_INTERNAL: take_type = int_type;
            SRC_NMI:      take_type = TYPE_W'(TYPE_NMI);
            SRC_STEP:     take_type = TYPE_W'(TYPE_STEP);
            default:      take_type = '0;
        endcase
    end

    // Edge detector and pending latch; a fresh edge wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_prev <= nmi_pin;
            if (nmi_rise)                           nmi_pend <= 1'b1;
            else if (take && winner == SRC_NMI)     nmi_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_flags.sv
// Flag word register: loaded by the execute stage while no entry runs,
// trap and enable bits cleared by the sequencer after the flag push.
module irq_flags
    import irq_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              ld,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              clr_ift,
    output logic [WORD_W-1:0] q
);
    // Hold, load or clear the flag word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr_ift) begin
            q[FLAG_IF] <= 1'b0;
            q[FLAG_TF] <= 1'b0;
        end else if (ld && !busy) begin
            q <= ld_data;
        end
    end
endmodule

// File: rtl/irq_bus_seq.sv
// Entry sequencer: optional acknowledge, three stack pushes with a
// pre-decremented stack pointer, two vector reads, completion pulse.
// Assumes: a bus cycle completes on the clock where mem_ready is high.
module irq_bus_seq
    import irq_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int SEG_SHIFT = 4,
    parameter int TYPE_W    = 8,
    parameter int ADDR_W    = WORD_W + SEG_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              take_ack,
    input  logic [TYPE_W-1:0] take_type,
    input  logic [WORD_W-1:0] cs_cur,
    input  logic [WORD_W-1:0] ip_cur,
    input  logic [WORD_W-1:0] ss_cur,
    input  logic [WORD_W-1:0] sp_cur,
    input  logic [WORD_W-1:0] flags_cur,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              inta_n,
    output logic              clr_ift,
    output logic              idle,
    output logic              entry_done,
    output logic [TYPE_W-1:0] vec_type,
    output logic [WORD_W-1:0] cs_new,
    output logic [WORD_W-1:0] ip_new,
    output logic [WORD_W-1:0] sp_new
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int VEC_SHIFT  = $clog2(2 * WORD_BYTES);

    seq_state_t        state;
    logic [TYPE_W-1:0] type_q;
    logic [WORD_W-1:0] cs_q, ip_q, ss_q, sp_q;
    logic [ADDR_W-1:0] stk_addr, vec_addr;
    logic              is_push;

    assign is_push  = (state == ST_PSH_FL) || (state == ST_PSH_CS) || (state == ST_PSH_IP);
    assign stk_addr = (ADDR_W'(ss_q) << SEG_SHIFT) + ADDR_W'(sp_q - WORD_W'(WORD_BYTES));
    assign vec_addr = ADDR_W'(type_q) << VEC_SHIFT;

    // Bus drive for the current step.
    always_comb begin
        mem_req   = is_push || (state == ST_VEC_LO) || (state == ST_VEC_HI);
        mem_we    = is_push;
        mem_addr  = is_push ? stk_addr : vec_addr;
        if (state == ST_VEC_HI) mem_addr = vec_addr + ADDR_W'(WORD_BYTES);
        unique case (state)
            ST_PSH_CS: mem_wdata = cs_q;
            ST_PSH_IP: mem_wdata = ip_q;
            default:   mem_wdata = flags_cur;
        endcase
        inta_n     = (state != ST_ACK);
        clr_ift    = (state == ST_PSH_FL) && mem_ready;
        idle       = (state == ST_IDLE);
        entry_done = (state == ST_DONE);
    end

    assign vec_type = type_q;
    assign sp_new   = sp_q;

    // Step through the entry sequence, advancing on each completed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            type_q <= '0;
            cs_q   <= '0;
            ip_q   <= '0;
            ss_q   <= '0;
            sp_q   <= '0;
            cs_new <= '0;
            ip_new <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (take) begin
                    type_q <= take_type;
                    cs_q   <= cs_cur;
                    ip_q   <= ip_cur;
                    ss_q   <= ss_cur;
                    sp_q   <= sp_cur;
                    state  <= take_ack ? ST_ACK : ST_PSH_FL;
                end
                ST_ACK: if (mem_ready) begin
                    type_q <= mem_rdata[TYPE_W-1:0];
                    state  <= ST_PSH_FL;
                end
                ST_PSH_FL: if (mem_ready) begin
                    sp_q  <= sp_q - WORD_W'(WORD_BYTES);
                    state <= ST_PSH_CS;
                end
                ST_PSH_CS: if (mem_ready) begin
                    sp_q  <= sp_q - WORD_W'(WORD_BYTES);
                    state <= ST_PSH_IP;
                end
                ST_PSH_IP: if (mem_ready) begin
                    sp_q  <= sp_q - WORD_W'(WORD_BYTES);
                    state <= ST_VEC_LO;
                end
                ST_VEC_LO: if (mem_ready) begin
                    ip_new <= mem_rdata;
                    state  <= ST_VEC_HI;
                end
                ST_VEC_HI: if (mem_ready) begin
                    cs_new <= mem_rdata;
                    state  <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Top of the interrupt entry sequencer: arbiter, flag register and bus
// sequencer, plus the wait/test stall. Assumes the execute stage pulses
// inst_end only at instruction boundaries and samples results on entry_done.
module irq_entry_seq
    import irq_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int SEG_SHIFT = 4,
    parameter int TYPE_W    = 8,
    localparam int ADDR_W   = WORD_W + SEG_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inst_end,
    input  logic              nmi_pin,
    input  logic              intr_pin,
    input  logic              exc_req,
    input  logic [1:0]        exc_sel,
    input  logic              into_req,
    input  logic              swi_req,
    input  logic [TYPE_W-1:0] swi_type,
    input  logic              flags_ld,
    input  logic [WORD_W-1:0] flags_d,
    input  logic [WORD_W-1:0] cs_cur,
    input  logic [WORD_W-1:0] ip_cur,
    input  logic [WORD_W-1:0] ss_cur,
    input  logic [WORD_W-1:0] sp_cur,
    input  logic              wait_req,
    input  logic              test_pin,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              inta_n,
    output logic              busy,
    output logic              entry_done,
    output logic [TYPE_W-1:0] vec_type,
    output logic [WORD_W-1:0] cs_new,
    output logic [WORD_W-1:0] ip_new,
    output logic [WORD_W-1:0] sp_new,
    output logic [WORD_W-1:0] flags_q,
    output logic              wait_stall
);
    logic              idle, take, take_ack, clr_ift;
    logic [TYPE_W-1:0] take_type;

    assign busy       = !idle;
    assign wait_stall = wait_req && test_pin;

    irq_arbiter #(.TYPE_W(TYPE_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .idle(idle), .inst_end(inst_end),
        .nmi_pin(nmi_pin), .intr_pin(intr_pin),
        .flag_if(flags_q[FLAG_IF]), .flag_tf(flags_q[FLAG_TF]), .flag_of(flags_q[FLAG_OF]),
        .exc_req(exc_req), .exc_sel(exc_sel), .into_req(into_req),
        .swi_req(swi_req), .swi_type(swi_type),
        .take(take), .take_ack(take_ack), .take_type(take_type)
    );

    irq_flags #(.WORD_W(WORD_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .busy(busy), .ld(flags_ld),
        .ld_data(flags_d), .clr_ift(clr_ift), .q(flags_q)
    );

    irq_bus_seq #(.WORD_W(WORD_W), .SEG_SHIFT(SEG_SHIFT), .TYPE_W(TYPE_W), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .take(take), .take_ack(take_ack), .take_type(take_type),
        .cs_cur(cs_cur), .ip_cur(ip_cur), .ss_cur(ss_cur), .sp_cur(sp_cur),
        .flags_cur(flags_q), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .inta_n(inta_n), .clr_ift(clr_ift), .idle(idle), .entry_done(entry_done),
        .vec_type(vec_type), .cs_new(cs_new), .ip_new(ip_new), .sp_new(sp_new)
    );
endmodule

// File: rtl/irq_entry_seq_checker.sv
// Protocol checker bound to the entry sequencer top.
module irq_entry_seq_checker #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              inta_n,
    input logic              busy,
    input logic              entry_done,
    input logic [WORD_W-1:0] flags_q
);
    // R1: first cycle after reset is quiet.
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!mem_req && inta_n && !busy));

    // R2: stack writes only happen inside a sequence and never with the acknowledge.
    assert_write_in_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (busy && inta_n));

    // R3: trap and enable bits are clear at completion.
    assert_flags_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |-> (!flags_q[9] && !flags_q[8]));

    // R4: completion is a single-cycle pulse followed by idle.
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done |=> (!entry_done && !busy));

    // R6: the acknowledge handshake never overlaps a memory cycle.
    assert_ack_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_n |-> !mem_req);

    // R11: a cycle without ready is held unchanged.
    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind irq_entry_seq irq_entry_seq_checker #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .inta_n(inta_n), .busy(busy),
    .entry_done(entry_done), .flags_q(flags_q)
);

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inst_end = 0, nmi_pin = 0, intr_pin = 0, exc_req = 0, into_req = 0, swi_req = 0;
    logic [1:0]  exc_sel = 0;
    logic [7:0]  swi_type = 0;
    logic        flags_ld = 0;
    logic [15:0] flags_d = 0;
    logic [15:0] cs_cur = 16'h1234, ip_cur = 16'h5678, ss_cur = 16'h3000, sp_cur = 16'h0100;
    logic        wait_req = 0, test_pin = 0;
    logic [15:0] mem_rdata = 0;
    logic        mem_ready = 0;
    logic        mem_req, mem_we, inta_n, busy, entry_done, wait_stall;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, cs_new, ip_new, sp_new, flags_q;
    logic [7:0]  vec_type;

    irq_entry_seq u_irq_entry_seq (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int wait_cycles = 0, wait_ctr = 0, stall_bad = 0, ack_cnt = 0;
    logic [7:0]  ack_byte = 8'h40;
    logic [19:0] hold_addr;
    logic [19:0] w_addr[8];
    logic [15:0] w_data[8];
    logic [19:0] r_addr[8];
    int wcnt = 0, rcnt = 0;

    // Memory and acknowledge responder, acting between clock edges.
    always @(negedge clk) begin
        if (mem_req || !inta_n) begin
            if (wait_ctr > 0 && mem_addr != hold_addr) stall_bad++;
            hold_addr = mem_addr;
            if (wait_ctr < wait_cycles) begin
                mem_ready = 1'b0;
                wait_ctr++;
            end else begin
                mem_ready = 1'b1;
                wait_ctr = 0;
                if (!inta_n) begin
                    mem_rdata = {8'h00, ack_byte};
                    ack_cnt++;
                end else if (mem_we) begin
                    if (wcnt < 8) begin w_addr[wcnt] = mem_addr; w_data[wcnt] = mem_wdata; end
                    wcnt++;
                end else begin
                    if (rcnt < 8) r_addr[rcnt] = mem_addr;
                    rcnt++;
                    mem_rdata = mem_addr[1] ? (16'h2000 + 16'(mem_addr[9:2]))
                                            : (16'h1000 + {6'd0, mem_addr[9:2], 2'b00});
                end
            end
        end else begin
            mem_ready = 1'b0;
            wait_ctr = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        wcnt = 0; rcnt = 0; ack_cnt = 0; stall_bad = 0;
    endtask

    task automatic load_flags(input logic [15:0] v);
        @(negedge clk); flags_ld = 1; flags_d = v;
        @(negedge clk); flags_ld = 0;
    endtask

    task automatic boundary();
        @(negedge clk); inst_end = 1;
        @(negedge clk); inst_end = 0;
    endtask

    function automatic logic [19:0] stk(input int k);
        return {ss_cur, 4'h0} + 20'(sp_cur - 16'(2 * k));
    endfunction

    // Wait for completion, then compare every observable result of one entry.
    task automatic finish_entry(input string tag, input logic [7:0] t, input logic [15:0] pushed, input int acks);
        bit got = 0;
        for (int i = 0; i < 200 && !got; i++) begin
            @(negedge clk);
            if (entry_done) got = 1;
        end
        chk(got, {tag, " R4 done pulse"}, 32'(got), 1);
        chk(vec_type == t, {tag, " R8 type"}, 32'(vec_type), 32'(t));
        chk(wcnt == 3 && w_addr[0] == stk(1) && w_addr[1] == stk(2) && w_addr[2] == stk(3),
            {tag, " R2 push addresses"}, 32'(w_addr[2]), 32'(stk(3)));
        chk(w_data[0] == pushed, {tag, " R3 pushed flags"}, 32'(w_data[0]), 32'(pushed));
        chk(w_data[1] == cs_cur && w_data[2] == ip_cur, {tag, " R2 cs/ip push"},
            {w_data[1], w_data[2]}, {cs_cur, ip_cur});
        chk(sp_new == sp_cur - 16'd6, {tag, " R2 sp_new"}, 32'(sp_new), 32'(sp_cur - 16'd6));
        chk(rcnt == 2 && r_addr[0] == {10'd0, t, 2'b00} && r_addr[1] == {10'd0, t, 2'b10},
            {tag, " R4 vector addresses"}, 32'(r_addr[0]), 32'({t, 2'b00}));
        chk(ip_new == 16'h1000 + {6'd0, t, 2'b00} && cs_new == 16'h2000 + 16'(t),
            {tag, " R4 new cs/ip"}, {cs_new, ip_new}, {16'h2000 + 16'(t), 16'h1000 + {6'd0, t, 2'b00}});
        chk(flags_q == (pushed & 16'hFCFF), {tag, " R3 flags after"}, 32'(flags_q), 32'(pushed & 16'hFCFF));
        chk(ack_cnt == acks, {tag, " R6 acknowledge count"}, 32'(ack_cnt), 32'(acks));
        @(negedge clk);
        chk(!busy && !entry_done, {tag, " R4 back to idle"}, 32'(busy), 0);
    endtask

    task automatic expect_none(input string tag);
        clear_logs();
        boundary();
        chk(!busy, {tag, " not started"}, 32'(busy), 0);
        repeat (6) @(negedge clk);
        chk(wcnt == 0 && !busy, {tag, " no bus activity"}, 32'(wcnt), 0);
    endtask

    task automatic t_reset();
        chk(!mem_req && inta_n && !busy && !entry_done, "R1 quiet after reset", 32'(mem_req), 0);
        chk(flags_q == 16'h0000, "R1 flags zero", 32'(flags_q), 0);
        expect_none("R1 bare boundary");
    endtask

    task automatic t_software();
        logic [15:0] f;
        load_flags(16'h0300);
        f = flags_q;
        clear_logs();
        swi_req = 1; swi_type = 8'h21;
        boundary();
        swi_req = 0;
        finish_entry("R8 software type 21", 8'h21, f, 0);
    endtask

    task automatic t_exceptions();
        logic [7:0] tbl[4] = '{8'd0, 8'd3, 8'd6, 8'd7};
        for (int s = 0; s < 4; s++) begin
            load_flags(16'h0200);
            clear_logs();
            exc_req = 1; exc_sel = 2'(s);
            boundary();
            exc_req = 0;
            finish_entry("R8 exception", tbl[s], 16'h0200, 0);
        end
    endtask

    task automatic t_overflow();
        load_flags(16'h0200);
        into_req = 1;
        expect_none("R9 overflow with OF clear");
        into_req = 0;
        load_flags(16'h0A00);
        clear_logs();
        into_req = 1;
        boundary();
        into_req = 0;
        finish_entry("R8 overflow type", 8'd4, 16'h0A00, 0);
    endtask

    task automatic t_intr();
        load_flags(16'h0000);
        intr_pin = 1;
        expect_none("R6 masked request");
        load_flags(16'h0200);
        clear_logs();
        ack_byte = 8'h40;
        boundary();
        intr_pin = 0;
        finish_entry("R6 acknowledged request", 8'h40, 16'h0200, 1);
    endtask

    task automatic t_nmi();
        load_flags(16'h0000);
        @(negedge clk); nmi_pin = 1;
        @(negedge clk);
        clear_logs();
        boundary();
        finish_entry("R5 rising edge", 8'd2, 16'h0000, 0);
        expect_none("R5 held level");
        @(negedge clk); nmi_pin = 0;
        // Edge raised while another entry is running must be kept.
        clear_logs();
        swi_req = 1; swi_type = 8'h10;
        boundary();
        swi_req = 0;
        nmi_pin = 1;
        finish_entry("R5 entry during edge", 8'h10, 16'h0000, 0);
        nmi_pin = 0;
        clear_logs();
        boundary();
        finish_entry("R5 latched edge", 8'd2, 16'h0000, 0);
    endtask

    task automatic t_priority();
        load_flags(16'h0300);
        @(negedge clk); nmi_pin = 1;
        @(negedge clk);
        intr_pin = 1; exc_req = 1; exc_sel = 2'd2;
        clear_logs();
        boundary();
        exc_req = 0;
        finish_entry("R7 internal first", 8'd6, 16'h0300, 0);
        clear_logs();
        boundary();
        finish_entry("R7 edge before pin", 8'd2, 16'h0000, 0);
        nmi_pin = 0;
        load_flags(16'h0300);
        clear_logs();
        ack_byte = 8'h55;
        boundary();
        finish_entry("R7 pin before step", 8'h55, 16'h0300, 1);
        load_flags(16'h0100);
        clear_logs();
        boundary();
        intr_pin = 0;
        finish_entry("R7 step last", 8'd1, 16'h0100, 0);
    endtask

    task automatic t_wait();
        @(negedge clk); wait_req = 1; test_pin = 1;
        @(negedge clk);
        chk(wait_stall, "R10 stall while test high", 32'(wait_stall), 1);
        test_pin = 0;
        @(negedge clk);
        chk(!wait_stall, "R10 resume on test low", 32'(wait_stall), 0);
        wait_req = 0;
    endtask

    task automatic t_stretch();
        load_flags(16'h0A00);
        wait_cycles = 2;
        clear_logs();
        swi_req = 1; swi_type = 8'h80;
        boundary();
        swi_req = 0;
        flags_ld = 1; flags_d = 16'hFFFF;
        @(negedge clk);
        flags_ld = 0;
        finish_entry("R12 load while busy", 8'h80, 16'h0A00, 0);
        chk(stall_bad == 0, "R11 address held in wait", 32'(stall_bad), 0);
        wait_cycles = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_software();
        t_exceptions();
        t_overflow();
        t_intr();
        t_nmi();
        t_priority();
        t_wait();
        t_stretch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule